// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block sits next to an 8-bit processor core and takes over the core's bus while an interrupt is entered or left. When the core reports an instruction boundary and a request may be taken, the block copies the core's registers into a snapshot. It writes them to a byte-wide stack in memory and reads the 16-bit handler address from a two-byte vector. It then hands the core a new program counter and a condition-code byte with the interrupt mask set.

A software trap uses the same entry path and ignores the mask. A return strobe runs the sequence backwards. The block pops the saved bytes and loads the core's program counter, index register, accumulator and condition codes with the values it read. The mask ends up in whatever state the popped condition codes hold. For an interrupt that was taken with the mask clear, that leaves it cleared.

The memory port expects a synchronous read: data for a read issued in one cycle is presented in the next cycle. The stack pointer belongs to the block and can be read on a port.

Top module: `irq_seq_top`

## Requirements
- R1: After reset the block is idle. `busy` is 0, `sp_out` equals SP_INIT (default 8'hFF), and `pc_ld`, `cc_ld`, `xa_ld` and `mem_we` are 0.
- R2: An interrupt request is accepted only in a cycle where the block is idle, `instr_done` is 1 and bit 3 of `cc_in` (the mask bit) is 0. A request without `instr_done`, or with the mask bit at 1, starts nothing.
- R3: Entry writes exactly five bytes in consecutive cycles: PC low, PC high, X, A, then CC as presented at acceptance. The first byte goes to address {STACK_PAGE, sp}. The pointer decrements after each write, so the bytes land at descending addresses and `sp_out` ends 5 below its start.
- R4: After the pushes the block reads the high vector byte at the vector address and the low byte at the next address. `pc_out` becomes {high, low} with a one-cycle `pc_ld`, visible 9 clock edges after the accepting edge.
- R5: On entry `cc_out` equals the saved CC with bit 3 set, and `cc_ld` pulses together with `pc_ld`. `xa_ld` stays 0.
- R6: A trap strobe with `instr_done` enters whatever the mask bit holds. It uses the TRAP_VEC vector address and wins over a simultaneous interrupt request.
- R7: A return strobe pops five bytes, incrementing the pointer before each read, in the order CC, A, X, PC high, PC low. It then loads `pc_out`, `x_out`, `a_out` and `cc_out` with the popped values and pulses `pc_ld`, `cc_ld` and `xa_ld` 7 edges after the accepting edge. The pointer returns to its value from before entry. A saved CC with bit 3 clear therefore leaves the mask cleared.
- R8: `busy` is 1 from the edge after acceptance until the load edge. Trap, interrupt and return strobes that arrive while busy are ignored.
- R9: When a return strobe and an entry request arrive together at an idle block, the return is performed and nothing is pushed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_done | input | 1 | Current instruction has completed |
| irq_req | input | 1 | Maskable request from the priority unit |
| irq_vec | input | 16 | Vector address of the winning request |
| trap_req | input | 1 | Software trap instruction executed |
| iret_req | input | 1 | Return-from-interrupt executed |
| pc_in | input | 16 | Core program counter to save |
| x_in | input | 8 | Core index register to save |
| a_in | input | 8 | Core accumulator to save |
| cc_in | input | 8 | Core condition codes (bit 3 = mask) |
| mem_we | output | 1 | Stack memory write enable |
| mem_re | output | 1 | Memory read enable (data next cycle) |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 8 | Byte to write |
| mem_rdata | input | 8 | Byte read, one cycle after `mem_re` |
| pc_out | output | 16 | Program counter to load |
| pc_ld | output | 1 | Load strobe for `pc_out` |
| x_out | output | 8 | Index register to load |
| a_out | output | 8 | Accumulator to load |
| xa_ld | output | 1 | Load strobe for `x_out` and `a_out` |
| cc_out | output | 8 | Condition codes to load |
| cc_ld | output | 1 | Load strobe for `cc_out` |
| sp_out | output | 8 | Stack pointer (low byte of stack address) |
| busy | output | 1 | A save or restore sequence is in progress |

## Verification
The hardest cases to reach from the ports are strobes that arrive in the middle of a running sequence. They cannot be sent from an idle state. The trap scenario raises trap, interrupt and boundary strobes two cycles after acceptance, while the pushes are still running. The bench then counts every memory write over the whole sequence and checks the final stack pointer, which shows that no second entry began. Two more cases work the same way. One takes a trap with the mask set and returns from it, which shows that the mask stays set when the popped byte carries it. The other presents a return and an entry together, right after a fresh entry has filled the stack.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
  typedef enum logic [3:0] {
    S_IDLE,
    S_PUSH_PCL, S_PUSH_PCH, S_PUSH_X, S_PUSH_A, S_PUSH_CC,
    S_VEC_HI, S_VEC_LO, S_VEC_FIN,
    S_POP_CC, S_POP_A, S_POP_X, S_POP_PCH, S_POP_PCL, S_RET_FIN
  } seq_state_e;
endpackage

// File: rtl/irq_seq_ctrl.sv
module irq_seq_ctrl
  import irq_seq_pkg::*;
#(
  parameter int SP_W = 8,
  parameter logic [SP_W-1:0] SP_INIT = '1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            instr_done,
  input  logic            irq_req,
  input  logic            trap_req,
  input  logic            iret_req,
  input  logic            mask_bit,
  output seq_state_e      state,
  output logic [SP_W-1:0] sp,
  output logic [SP_W-1:0] stk_off,
  output logic            take_ent,
  output logic            take_trap,
  output logic            is_push,
  output logic            is_pop,
  output logic            busy
);
  localparam logic [SP_W-1:0] SP_ONE = 1;

  seq_state_e nxt;
  logic       idle, take_ret;

  assign idle      = (state == S_IDLE);
  assign take_ret  = idle && iret_req;
  assign take_ent  = idle && !iret_req && instr_done && (trap_req || (irq_req && !mask_bit));
  assign take_trap = take_ent && trap_req;
  assign is_push   = state inside {S_PUSH_PCL, S_PUSH_PCH, S_PUSH_X, S_PUSH_A, S_PUSH_CC};
  assign is_pop    = state inside {S_POP_CC, S_POP_A, S_POP_X, S_POP_PCH, S_POP_PCL};
  assign busy      = !idle;
  assign stk_off   = is_pop ? sp + SP_ONE : sp;

  always_comb begin
    nxt = state;
    case (state)
      S_IDLE:     if (take_ret) nxt = S_POP_CC;
                  else if (take_ent) nxt = S_PUSH_PCL;
      S_PUSH_PCL: nxt = S_PUSH_PCH;
      S_PUSH_PCH: nxt = S_PUSH_X;
      S_PUSH_X:   nxt = S_PUSH_A;
      S_PUSH_A:   nxt = S_PUSH_CC;
      S_PUSH_CC:  nxt = S_VEC_HI;
      S_VEC_HI:   nxt = S_VEC_LO;
      S_VEC_LO:   nxt = S_VEC_FIN;
      S_VEC_FIN:  nxt = S_IDLE;
      S_POP_CC:   nxt = S_POP_A;
      S_POP_A:    nxt = S_POP_X;
      S_POP_X:    nxt = S_POP_PCH;
      S_POP_PCH:  nxt = S_POP_PCL;
      S_POP_PCL:  nxt = S_RET_FIN;
      S_RET_FIN:  nxt = S_IDLE;
      default:    nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_IDLE;
      sp    <= SP_INIT;
    end else begin
      state <= nxt;
      if (is_push)     sp <= sp - SP_ONE;
      else if (is_pop) sp <= sp + SP_ONE;
    end
  end

  // R3: a push writes at the current pointer, which then steps down
  p_sp_down_r3: assert property (@(posedge clk) disable iff (rst)
    is_push |=> sp == $past(sp) - SP_ONE);
  // R3: five pushes follow each other in fixed order
  p_push_seq_r3: assert property (@(posedge clk) disable iff (rst)
    state == S_PUSH_PCL |=> state == S_PUSH_PCH);
  // R7: every pop moves the pointer up by one
  p_sp_up_r7: assert property (@(posedge clk) disable iff (rst)
    is_pop |=> sp == $past(sp) + SP_ONE);
  // R8: once busy, nothing is accepted until the final load state
  p_busy_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (busy && state != S_VEC_FIN && state != S_RET_FIN) |=> busy);
endmodule

// File: rtl/irq_seq_data.sv
module irq_seq_data
  import irq_seq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SP_W   = 8,
  parameter int MASK_BIT = 3,
  parameter logic [2*DATA_W-SP_W-1:0] STACK_PAGE = 1,
  parameter logic [2*DATA_W-1:0] TRAP_VEC = 16'h03FC
) (
  input  logic                clk,
  input  logic                rst,
  input  seq_state_e          state,
  input  logic                take_ent,
  input  logic                take_trap,
  input  logic                is_push,
  input  logic                is_pop,
  input  logic [SP_W-1:0]     stk_off,
  input  logic [2*DATA_W-1:0] pc_in,
  input  logic [DATA_W-1:0]   x_in,
  input  logic [DATA_W-1:0]   a_in,
  input  logic [DATA_W-1:0]   cc_in,
  input  logic [2*DATA_W-1:0] irq_vec,
  input  logic [DATA_W-1:0]   mem_rdata,
  output logic                mem_we,
  output logic                mem_re,
  output logic [2*DATA_W-1:0] mem_addr,
  output logic [DATA_W-1:0]   mem_wdata,
  output logic [2*DATA_W-1:0] pc_out,
  output logic                pc_ld,
  output logic [DATA_W-1:0]   x_out,
  output logic [DATA_W-1:0]   a_out,
  output logic                xa_ld,
  output logic [DATA_W-1:0]   cc_out,
  output logic                cc_ld
);
  localparam int PC_W = 2 * DATA_W;
  localparam logic [PC_W-1:0]   A_ONE = 1;
  localparam logic [DATA_W-1:0] MASK  = {{(DATA_W-1){1'b0}}, 1'b1} << MASK_BIT;

  logic [PC_W-1:0]   snap_pc, vec_q;
  logic [DATA_W-1:0] snap_x, snap_a, snap_cc;
  logic [DATA_W-1:0] vhi_q, cc_r, a_r, x_r, pch_r;

  assign mem_we = is_push;
  assign mem_re = is_pop || state == S_VEC_HI || state == S_VEC_LO;

  always_comb begin
    mem_addr = '0;
    if (is_push || is_pop)     mem_addr = {STACK_PAGE, stk_off};
    else if (state == S_VEC_HI) mem_addr = vec_q;
    else if (state == S_VEC_LO) mem_addr = vec_q + A_ONE;
  end

  always_comb begin
    case (state)
      S_PUSH_PCL: mem_wdata = snap_pc[DATA_W-1:0];
      S_PUSH_PCH: mem_wdata = snap_pc[PC_W-1:DATA_W];
      S_PUSH_X:   mem_wdata = snap_x;
      S_PUSH_A:   mem_wdata = snap_a;
      S_PUSH_CC:  mem_wdata = snap_cc;
      default:    mem_wdata = '0;
    endcase
  end

  // snapshot at acceptance frees the core's register buses during the pushes
  always_ff @(posedge clk) begin
    if (rst) begin
      snap_pc <= '0; snap_x <= '0; snap_a <= '0; snap_cc <= '0; vec_q <= '0;
    end else if (take_ent) begin
      snap_pc <= pc_in;
      snap_x  <= x_in;
      snap_a  <= a_in;
      snap_cc <= cc_in;
      vec_q   <= take_trap ? TRAP_VEC : irq_vec;
    end
  end

  // read data arrives one state after its address
  always_ff @(posedge clk) begin
    if (rst) begin
      vhi_q <= '0; cc_r <= '0; a_r <= '0; x_r <= '0; pch_r <= '0;
    end else begin
      case (state)
        S_VEC_LO:  vhi_q <= mem_rdata;
        S_POP_A:   cc_r  <= mem_rdata;
        S_POP_X:   a_r   <= mem_rdata;
        S_POP_PCH: x_r   <= mem_rdata;
        S_POP_PCL: pch_r <= mem_rdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_out <= '0; x_out <= '0; a_out <= '0; cc_out <= '0;
      pc_ld  <= 1'b0; cc_ld <= 1'b0; xa_ld <= 1'b0;
    end else begin
      pc_ld <= 1'b0; cc_ld <= 1'b0; xa_ld <= 1'b0;
      if (state == S_VEC_FIN) begin
        pc_out <= {vhi_q, mem_rdata};
        cc_out <= snap_cc | MASK;
        pc_ld  <= 1'b1;
        cc_ld  <= 1'b1;
      end else if (state == S_RET_FIN) begin
        pc_out <= {pch_r, mem_rdata};
        cc_out <= cc_r;
        x_out  <= x_r;
        a_out  <= a_r;
        pc_ld  <= 1'b1;
        cc_ld  <= 1'b1;
        xa_ld  <= 1'b1;
      end
    end
  end

  // R5: entry ends with the mask set and only PC/CC loaded
  p_entry_mask_r5: assert property (@(posedge clk) disable iff (rst)
    state == S_VEC_FIN |=> cc_ld && cc_out[MASK_BIT] && !xa_ld);
  // R7: return ends by loading every register
  p_ret_loads_r7: assert property (@(posedge clk) disable iff (rst)
    state == S_RET_FIN |=> pc_ld && cc_ld && xa_ld);
  // R4: the program counter is never loaded without the condition codes
  p_pc_cc_pair_r4: assert property (@(posedge clk) disable iff (rst)
    pc_ld |-> cc_ld);
  // R3: the port never reads and writes in the same cycle
  p_rw_excl_r3: assert property (@(posedge clk) disable iff (rst)
    !(mem_we && mem_re));
endmodule

// File: rtl/irq_seq_top.sv
module irq_seq_top
  import irq_seq_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int SP_W     = 8,
  parameter int MASK_BIT = 3,
  parameter logic [SP_W-1:0] SP_INIT = '1,
  parameter logic [2*DATA_W-SP_W-1:0] STACK_PAGE = 1,
  parameter logic [2*DATA_W-1:0] TRAP_VEC = 16'h03FC
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                instr_done,
  input  logic                irq_req,
  input  logic [2*DATA_W-1:0] irq_vec,
  input  logic                trap_req,
  input  logic                iret_req,
  input  logic [2*DATA_W-1:0] pc_in,
  input  logic [DATA_W-1:0]   x_in,
  input  logic [DATA_W-1:0]   a_in,
  input  logic [DATA_W-1:0]   cc_in,
  output logic                mem_we,
  output logic                mem_re,
  output logic [2*DATA_W-1:0] mem_addr,
  output logic [DATA_W-1:0]   mem_wdata,
  input  logic [DATA_W-1:0]   mem_rdata,
  output logic [2*DATA_W-1:0] pc_out,
  output logic                pc_ld,
  output logic [DATA_W-1:0]   x_out,
  output logic [DATA_W-1:0]   a_out,
  output logic                xa_ld,
  output logic [DATA_W-1:0]   cc_out,
  output logic                cc_ld,
  output logic [SP_W-1:0]     sp_out,
  output logic                busy
);
  seq_state_e      state;
  logic [SP_W-1:0] stk_off;
  logic            take_ent, take_trap, is_push, is_pop;

  irq_seq_ctrl #(.SP_W(SP_W), .SP_INIT(SP_INIT)) u_ctrl (
    .clk(clk), .rst(rst), .instr_done(instr_done), .irq_req(irq_req),
    .trap_req(trap_req), .iret_req(iret_req), .mask_bit(cc_in[MASK_BIT]),
    .state(state), .sp(sp_out), .stk_off(stk_off), .take_ent(take_ent),
    .take_trap(take_trap), .is_push(is_push), .is_pop(is_pop), .busy(busy)
  );

  irq_seq_data #(
    .DATA_W(DATA_W), .SP_W(SP_W), .MASK_BIT(MASK_BIT),
    .STACK_PAGE(STACK_PAGE), .TRAP_VEC(TRAP_VEC)
  ) u_data (
    .clk(clk), .rst(rst), .state(state), .take_ent(take_ent),
    .take_trap(take_trap), .is_push(is_push), .is_pop(is_pop),
    .stk_off(stk_off), .pc_in(pc_in), .x_in(x_in), .a_in(a_in),
    .cc_in(cc_in), .irq_vec(irq_vec), .mem_rdata(mem_rdata),
    .mem_we(mem_we), .mem_re(mem_re), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .pc_out(pc_out), .pc_ld(pc_ld),
    .x_out(x_out), .a_out(a_out), .xa_ld(xa_ld), .cc_out(cc_out),
    .cc_ld(cc_ld)
  );

  // R2: a maskable entry needs the boundary strobe
  p_need_boundary_r2: assert property (@(posedge clk) disable iff (rst)
    (!busy && !instr_done) |=> !mem_we);
endmodule

// File: tb/tb_irq_seq_top.sv
module tb_irq_seq_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        instr_done = 0, irq_req = 0, trap_req = 0, iret_req = 0;
  logic [15:0] irq_vec = 16'h03F8, pc_in = 0;
  logic [7:0]  x_in = 0, a_in = 0, cc_in = 0;
  logic        mem_we, mem_re, pc_ld, xa_ld, cc_ld, busy;
  logic [15:0] mem_addr, pc_out;
  logic [7:0]  mem_wdata, x_out, a_out, cc_out, sp_out;
  logic [7:0]  mem_rdata = 0;
  logic [7:0]  mem [0:1023];
  int          checks = 0, errors = 0, wr_cnt = 0;
  bit          finished = 0;

  always #2.5 clk = ~clk;

  irq_seq_top dut (
    .clk(clk), .rst(rst), .instr_done(instr_done), .irq_req(irq_req),
    .irq_vec(irq_vec), .trap_req(trap_req), .iret_req(iret_req),
    .pc_in(pc_in), .x_in(x_in), .a_in(a_in), .cc_in(cc_in),
    .mem_we(mem_we), .mem_re(mem_re), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .pc_out(pc_out),
    .pc_ld(pc_ld), .x_out(x_out), .a_out(a_out), .xa_ld(xa_ld),
    .cc_out(cc_out), .cc_ld(cc_ld), .sp_out(sp_out), .busy(busy)
  );

  always @(posedge clk) begin
    if (mem_we) begin
      mem[mem_addr[9:0]] <= mem_wdata;
      wr_cnt <= wr_cnt + 1;
    end
    if (mem_re) mem_rdata <= mem[mem_addr[9:0]];
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // strobes set at a negedge count as accepted on the next posedge;
  // n counts following negedges until pc_ld is seen
  task automatic run_seq(output int n, input bit ent, input bit trp, input bit irq, input bit ret);
    instr_done = ent; trap_req = trp; irq_req = irq; iret_req = ret;
    n = 0;
    do begin
      @(negedge clk);
      n++;
      if (n == 1) begin instr_done = 0; trap_req = 0; irq_req = 0; iret_req = 0; end
    end while (!pc_ld && n < 30);
  endtask

  task automatic t_reset;
    chk(busy == 0, "R1 busy", busy, 0);
    chk(sp_out == 8'hFF, "R1 sp", sp_out, 8'hFF);
    chk({pc_ld, cc_ld, xa_ld, mem_we} == 0, "R1 strobes", {pc_ld, cc_ld, xa_ld, mem_we}, 0);
  endtask

  task automatic t_blocked;
    int w0;
    w0 = wr_cnt;
    cc_in = 8'h00; irq_req = 1;            // R2: no boundary strobe
    repeat (3) @(negedge clk);
    irq_req = 0;
    chk(busy == 0 && wr_cnt == w0, "R2 no boundary", wr_cnt - w0, 0);
    cc_in = 8'h08; irq_req = 1; instr_done = 1; // R2: mask bit 3 set
    @(negedge clk);
    irq_req = 0; instr_done = 0;
    repeat (3) @(negedge clk);
    chk(busy == 0 && wr_cnt == w0 && sp_out == 8'hFF, "R2 masked", wr_cnt - w0, 0);
  endtask

  task automatic t_irq_entry;
    int n, w0;
    pc_in = 16'hBEEF; x_in = 8'h11; a_in = 8'h22; cc_in = 8'h01;
    w0 = wr_cnt;
    run_seq(n, 1, 0, 1, 0);
    chk(n == 9, "R4 latency", n, 9);
    chk(pc_out == 16'h1234, "R4 vector", pc_out, 16'h1234);
    chk(cc_ld && cc_out == 8'h09, "R5 mask set", cc_out, 8'h09);
    chk(xa_ld == 0, "R5 no xa load", xa_ld, 0);
    chk(wr_cnt - w0 == 5, "R3 write count", wr_cnt - w0, 5);
    chk({mem[10'h1FF], mem[10'h1FE], mem[10'h1FD], mem[10'h1FC], mem[10'h1FB]} == 40'hEFBE112201,
        "R3 order", {mem[10'h1FF], mem[10'h1FE], mem[10'h1FD], mem[10'h1FC], mem[10'h1FB]}, 32'hBE112201);
    chk(sp_out == 8'hFA, "R3 sp", sp_out, 8'hFA);
    @(negedge clk);
    chk(pc_ld == 0 && busy == 0, "R4 one-cycle load", pc_ld, 0);
  endtask

  task automatic t_return(input logic [15:0] epc, input logic [7:0] ecc, input logic [7:0] ex, input logic [7:0] ea);
    int n, w0;
    w0 = wr_cnt;
    cc_in = 8'h08;
    run_seq(n, 0, 0, 0, 1);
    chk(n == 7, "R7 latency", n, 7);
    chk(pc_out == epc, "R7 pc", pc_out, epc);
    chk(cc_out == ecc && cc_ld, "R7 cc", cc_out, ecc);
    chk({x_out, a_out} == {ex, ea} && xa_ld, "R7 x/a", {x_out, a_out}, {ex, ea});
    chk(sp_out == 8'hFF, "R7 sp", sp_out, 8'hFF);
    chk(wr_cnt == w0, "R7 no writes", wr_cnt - w0, 0);
  endtask

  task automatic t_trap_busy;
    int n, w0;
    pc_in = 16'h5566; x_in = 8'h77; a_in = 8'h88; cc_in = 8'h08;
    w0 = wr_cnt;
    instr_done = 1; trap_req = 1; irq_req = 1;
    n = 0;
    do begin
      @(negedge clk);
      n++;
      if (n == 1) begin
        instr_done = 0; trap_req = 0; irq_req = 0;
        chk(busy == 1, "R8 busy", busy, 1);
      end
      if (n == 2) begin instr_done = 1; trap_req = 1; irq_req = 1; end // R8: mid-sequence strobes
      if (n == 3) begin instr_done = 0; trap_req = 0; irq_req = 0; end
    end while (!pc_ld && n < 30);
    chk(n == 9, "R6 latency", n, 9);
    chk(pc_out == 16'hABCD, "R6 trap vector", pc_out, 16'hABCD);
    chk(cc_out == 8'h08, "R6 mask", cc_out, 8'h08);
    repeat (3) @(negedge clk);
    chk(wr_cnt - w0 == 5 && sp_out == 8'hFA, "R8 ignored", wr_cnt - w0, 5);
  endtask

  task automatic t_ret_priority;
    int n, w0;
    pc_in = 16'h4321; x_in = 8'h33; a_in = 8'h44; cc_in = 8'h00;
    run_seq(n, 1, 0, 1, 0);
    chk(n == 9 && cc_out == 8'h08, "R5 second entry", cc_out, 8'h08);
    w0 = wr_cnt;
    cc_in = 8'h00;
    run_seq(n, 1, 1, 1, 1);                // R9: all strobes together
    chk(n == 7 && wr_cnt == w0, "R9 return wins", wr_cnt - w0, 0);
    chk(pc_out == 16'h4321 && cc_out == 8'h00, "R9 restored", pc_out, 16'h4321);
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 8'h00;
    mem[10'h3F8] = 8'h12; mem[10'h3F9] = 8'h34;
    mem[10'h3FC] = 8'hAB; mem[10'h3FD] = 8'hCD;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_blocked();
    t_irq_entry();
    t_return(16'hBEEF, 8'h01, 8'h11, 8'h22);
    t_trap_busy();
    repeat (2) @(negedge clk);
    t_return(16'h5566, 8'h08, 8'h77, 8'h88);
    t_ret_priority();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule